// File: doc/BRIEF.md
# Four-Bank Interleaved Block Memory with One-Word Bus

This block models main memory behind a cache as several one-word-wide banks that share one block address. Word k of every block lives in bank k, so all words of a block are reached by a single parallel bank access. The path back to the cache stays one word wide, so a fetched block is sent out one word per bus cycle, lowest offset first. All latencies are counted in memory-bus clock cycles by one timing state machine.

A requester presents a block address with a read or write flag while `busy` is low. A read takes one address cycle, then one parallel access window of `ACCESS_CYC` cycles, then `NBANKS` transfer cycles with `rd_valid` high. A write takes the address cycle, then `NBANKS` cycles in which the block's words are taken from `wr_word` in ascending order (marked by `wr_take`), then one parallel access window in which all banks are written together. With the defaults (4 banks, 15-cycle access) either operation keeps `busy` high for exactly 1 + 15 + 4 = 20 cycles, against 65 for a single bank read word by word.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `wr_take` are all low and `rd_word` is zero.
- R2: A request is taken at a rising edge where `req_valid` is high and `busy` is low; `busy` is high in the next cycle and stays high for exactly 1 + `ACCESS_CYC` + `NBANKS` cycles (20 with defaults), then drops for at least one cycle.
- R3: For a read (`req_write` = 0), `rd_valid` is high in busy cycles 2 + `ACCESS_CYC` through 1 + `ACCESS_CYC` + `NBANKS` (cycles 17 to 20 with defaults, busy cycle 1 being the first) and low in every other cycle; `rd_word` is zero whenever `rd_valid` is low.
- R4: A read returns the block in ascending offset order: in the n-th `rd_valid` cycle (n from 0) `rd_word` is word n of the addressed block, i.e. the content of bank n.
- R5: For a write (`req_write` = 1), `wr_take` is high in busy cycles 2 to 1 + `NBANKS` (cycles 2 to 5) and low otherwise; the value on `wr_word` in the n-th `wr_take` cycle becomes word n of the block.
- R6: A write stores all words of the block at once at the end of its last busy cycle; a later read of the same address returns the new words, and blocks at other addresses keep their contents.
- R7: Requests presented while `busy` is high are ignored: they neither shorten nor extend the running operation, produce no `wr_take`, and change no stored block.
- R8: `rd_valid` and `wr_take` are never high while `busy` is low, and `rd_valid` is never high during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_blk_addr | input | BLK_AW | Block address shared by all banks |
| wr_word | input | WORD_W | Write word, taken when `wr_take` is high |
| wr_take | output | 1 | Current `wr_word` is consumed at this cycle's end |
| busy | output | 1 | Operation in progress; new requests ignored |
| rd_valid | output | 1 | `rd_word` carries a block word |
| rd_word | output | WORD_W | Read word, ascending offset order |

## Verification
The assertions assume that requests arrive only through `req_valid`/`req_write` and that a write's data is whatever sits on `wr_word` during `wr_take`; they make no assumption about the data values or about requests during `busy`, which must simply be ignored. The bench drives every input on the falling edge, offers requests while `busy` is high on purpose (including a write to another block), holds `req_valid` high across the end of an operation to probe the single idle cycle, and reads back only blocks it has already written so every expected word is known.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // cycles spent presenting the block address to the banks
  localparam int ADDR_CYCLES = 1;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_WDATA  = 3'd2,
    ST_ACCESS = 3'd3,
    ST_XFER   = 3'd4
  } ilv_state_e;

  // busy cycles of one block operation (read or write)
  function automatic int block_busy_cycles(input int nbanks, input int access_cyc);
    return ADDR_CYCLES + access_cyc + nbanks;
  endfunction

  // first busy cycle (1-based) carrying a read word
  function automatic int first_xfer_cycle(input int access_cyc);
    return ADDR_CYCLES + access_cyc + 1;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int WORD_W = 32,
  parameter int BLK_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BLK_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << BLK_AW;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/ilv_timer.sv
module ilv_timer
  import ilv_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int ACCESS_CYC = 15,
  parameter int BLK_AW     = 6,
  localparam int IDXW      = $clog2(NBANKS),
  localparam int CNT_MAX   = max_of(ACCESS_CYC, NBANKS),
  localparam int CW        = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BLK_AW-1:0] req_blk_addr,
  output logic              busy,
  output logic              rd_valid,
  output logic              wr_take,
  output logic [IDXW-1:0]   idx,
  output logic [BLK_AW-1:0] addr_q,
  output logic              evt_accept,
  output logic              evt_capture,
  output logic              evt_commit
);
  ilv_state_e st;
  logic [CW-1:0] cnt;
  logic op_wr;
  logic acc_done, slot_done;

  assign busy       = (st != ST_IDLE);
  assign evt_accept = req_valid && (st == ST_IDLE);
  assign acc_done   = (st == ST_ACCESS) && (cnt == CW'(ACCESS_CYC - 1));
  assign slot_done  = (cnt == CW'(NBANKS - 1));
  assign evt_capture = acc_done && !op_wr;
  assign evt_commit  = acc_done && op_wr;
  assign rd_valid   = (st == ST_XFER);
  assign wr_take    = (st == ST_WDATA);
  assign idx        = cnt[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      op_wr  <= 1'b0;
      addr_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (evt_accept) begin
            st     <= ST_ADDR;
            op_wr  <= req_write;
            addr_q <= req_blk_addr;
          end
        end
        ST_ADDR: begin
          cnt <= '0;
          st  <= op_wr ? ST_WDATA : ST_ACCESS;
        end
        ST_WDATA: begin
          if (slot_done) begin
            cnt <= '0;
            st  <= ST_ACCESS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACCESS: begin
          if (acc_done) begin
            cnt <= '0;
            st  <= op_wr ? ST_IDLE : ST_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (slot_done) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt <= '0;
          st  <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ilv_xfer_buf.sv
module ilv_xfer_buf #(
  parameter int NBANKS = 4,
  parameter int WORD_W = 32,
  localparam int IDXW  = $clog2(NBANKS)
) (
  input  logic                          clk,
  input  logic                          ld_one,
  input  logic [IDXW-1:0]               idx,
  input  logic [WORD_W-1:0]             one_word,
  input  logic                          ld_all,
  input  logic [NBANKS-1:0][WORD_W-1:0] all_words,
  output logic [NBANKS-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]             sel_word
);
  // one slot per bank; write data and read capture share the storage
  for (genvar k = 0; k < NBANKS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ld_all)
        words[k] <= all_words[k];
      else if (ld_one && (idx == IDXW'(k)))
        words[k] <= one_word;
    end
  end

  assign sel_word = words[idx];
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int ACCESS_CYC = 15,
  parameter int WORD_W     = 32,
  parameter int BLK_AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BLK_AW-1:0] req_blk_addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic              wr_take,
  output logic              busy,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word
);
  localparam int IDXW = $clog2(NBANKS);

  logic [IDXW-1:0]               idx;
  logic [BLK_AW-1:0]             addr_q;
  logic                          evt_accept, evt_capture, evt_commit;
  logic [NBANKS-1:0][WORD_W-1:0] bank_rd, buf_words;
  logic [WORD_W-1:0]             sel_word;

  ilv_timer #(
    .NBANKS(NBANKS), .ACCESS_CYC(ACCESS_CYC), .BLK_AW(BLK_AW)
  ) timer_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_blk_addr(req_blk_addr),
    .busy(busy), .rd_valid(rd_valid), .wr_take(wr_take), .idx(idx),
    .addr_q(addr_q), .evt_accept(evt_accept),
    .evt_capture(evt_capture), .evt_commit(evt_commit)
  );

  ilv_xfer_buf #(.NBANKS(NBANKS), .WORD_W(WORD_W)) buf_i (
    .clk(clk), .ld_one(wr_take), .idx(idx), .one_word(wr_word),
    .ld_all(evt_capture), .all_words(bank_rd),
    .words(buf_words), .sel_word(sel_word)
  );

  // word k of each block lives in bank k; every bank sees the same address
  for (genvar k = 0; k < NBANKS; k++) begin : g_bank
    ilv_bank #(.WORD_W(WORD_W), .BLK_AW(BLK_AW)) bank_i (
      .clk(clk), .we(evt_commit), .addr(addr_q),
      .wdata(buf_words[k]), .rdata(bank_rd[k])
    );
  end

  assign rd_word = rd_valid ? sel_word : '0;
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk
  import ilv_pkg::*;
#(
  parameter int NBANKS     = 4,
  parameter int ACCESS_CYC = 15
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_write,
  input logic busy,
  input logic rd_valid,
  input logic wr_take,
  input logic evt_capture,
  input logic evt_commit
);
  localparam int LAT = block_busy_cycles(NBANKS, ACCESS_CYC);

  int   bcnt;   // busy cycle index, 0 in the first busy cycle
  logic op_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= 0;
      op_w <= 1'b0;
    end else begin
      bcnt <= busy ? bcnt + 1 : 0;
      if (req_valid && !busy) op_w <= req_write;
    end
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
  a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bcnt) == LAT - 1));
  a_r3_valid_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !op_w && bcnt >= 1 + ACCESS_CYC && bcnt <= LAT - 1));
  a_r3_capture_then_send: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> rd_valid);
  a_r5_take_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (busy && op_w && bcnt >= 1 && bcnt <= NBANKS));
  a_r6_commit_last: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit |-> (op_w && bcnt == LAT - 1));
  a_r7_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt < LAT - 1) |=> busy);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_valid && !wr_take));
endmodule

bind ilv_mem_ctrl ilv_mem_chk #(.NBANKS(NBANKS), .ACCESS_CYC(ACCESS_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .busy(busy), .rd_valid(rd_valid), .wr_take(wr_take),
  .evt_capture(evt_capture), .evt_commit(evt_commit)
);

// File: tb/ilv_mem_ctrl_tb_top.sv
module ilv_mem_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int NB    = 4;
  localparam int ACC   = 15;
  localparam int W     = 32;
  localparam int AW    = 6;
  // restated timeline: address, access window, one cycle per word
  localparam int BUSY_N   = 1 + ACC + NB;
  localparam int XFER_1ST = BUSY_N - NB + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_blk_addr = '0;
  logic [W-1:0]  wr_word = '0;
  logic wr_take, busy, rd_valid;
  logic [W-1:0] rd_word;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NB-1:0][W-1:0] exp_mem [1 << AW];

  always #(CLK_P / 2) clk = ~clk;

  ilv_mem_ctrl #(.NBANKS(NB), .ACCESS_CYC(ACC), .WORD_W(W), .BLK_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_blk_addr(req_blk_addr), .wr_word(wr_word), .wr_take(wr_take),
    .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pat(input int a, input int seed, input int k);
    return W'((seed << 20) ^ (a << 8) ^ (k * 32'h11) ^ 32'hA500_0000);
  endfunction

  // R1: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(!busy, "R1 busy", W'(busy), 0);
    chk(!rd_valid, "R1 rd_valid", W'(rd_valid), 0);
    chk(!wr_take, "R1 wr_take", W'(wr_take), 0);
    chk(rd_word == '0, "R1 rd_word", rd_word, 0);
  endtask

  // R5 R6 R2: block write
  task automatic t_write(input int a, input int seed);
    req_valid = 1; req_write = 1; req_blk_addr = AW'(a);
    @(negedge clk);
    req_valid = 0;
    for (int c = 1; c <= BUSY_N; c++) begin
      bit tk = (c >= 2 && c <= 1 + NB);
      chk(busy, "R2 busy during write", W'(busy), 1);
      chk(wr_take == tk, "R5 wr_take window", W'(wr_take), W'(tk));
      chk(!rd_valid, "R8 no rd_valid in write", W'(rd_valid), 0);
      wr_word = tk ? pat(a, seed, c - 2) : W'(32'hDEAD_0000 + c);
      if (tk) exp_mem[a][c - 2] = pat(a, seed, c - 2);
      @(negedge clk);
    end
    chk(!busy, "R2 busy drops after write", W'(busy), 0);
  endtask

  // R3 R4 R7: block read, optional intruding write request / held request
  task automatic t_read(input int a, input bit intrude, input int other, input bit hold);
    req_valid = 1; req_write = 0; req_blk_addr = AW'(a);
    @(negedge clk);
    if (!hold) req_valid = 0;
    for (int c = 1; c <= BUSY_N; c++) begin
      bit v = (c >= XFER_1ST);
      if (intrude && c >= 3 && c <= 10) begin
        req_valid = 1; req_write = 1; req_blk_addr = AW'(other); wr_word = 32'hBAD0_0000 + c;
      end else if (!hold) begin
        req_valid = 0;
      end
      chk(busy, "R2 busy during read", W'(busy), 1);
      chk(rd_valid == v, "R3 rd_valid window", W'(rd_valid), W'(v));
      chk(!wr_take, "R7 no wr_take in read", W'(wr_take), 0);
      if (v) chk(rd_word == exp_mem[a][c - XFER_1ST], "R4 word order/data",
                 rd_word, exp_mem[a][c - XFER_1ST]);
      else   chk(rd_word == '0, "R3 rd_word idle zero", rd_word, 0);
      @(negedge clk);
    end
    chk(!busy, "R2 busy drops after read", W'(busy), 0);
    if (hold) begin
      @(negedge clk);
      chk(busy, "R2 held request taken after one idle cycle", W'(busy), 1);
      req_valid = 0;
      while (busy) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write(5, 1);
    t_read(5, 0, 0, 0);
    t_write(6, 2);
    t_read(6, 0, 0, 0);
    t_read(5, 0, 0, 0);            // R6: other block kept
    t_write(5, 3);                 // R6: overwrite
    t_read(5, 1, 6, 0);            // R7: write request to block 6 while busy
    t_read(6, 0, 0, 0);            // R7: block 6 untouched
    t_write(63, 4);
    t_read(63, 0, 0, 1);           // R2: held request
    t_read(0 + 5, 0, 0, 0);
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule